// File: doc/BRIEF.md
# Periodic Memory ECC Scrubber Controller

This block runs background scrub passes over an ECC-protected memory array. One pass visits every word in ascending address order. At each word it reads through the error check and correct stage, then writes the corrected word back to the same address. Each word access is a separate request to the memory arbiter, and the scrubber waits for a grant before moving on. Normal traffic can therefore slip in between scrub words.

Software controls the block through an 8-bit control register and a scrub-period register. Setting the enable bit starts a pass at once. While the enable bit stays set, passes repeat after a coarse interval. That interval is the period value times a tick, and the tick comes from a clock prescaler (nominally 2 s). Clearing the enable bit lets the current pass reach the last address, after which no further pass starts.

Single-bit corrections produce a log strobe and, if enabled, a one-cycle interrupt pulse. Multi-bit errors are handled according to an error-reporting mode input.

Top module: `mem_scrub_ctrl`

## Requirements
- R1: When the enable bit (control bit 3) changes from 0 to 1 while the scrubber is idle, a read request for address 0 appears in the cycle after the register write takes effect.
- R2: If the enable bit is clear when the last address of a pass completes, the scrubber goes idle and issues no further requests until the enable bit is set again.
- R3: If the enable bit is set when a pass completes, the first read of the next pass is requested after exactly max(P,1) × TICK_CYC idle cycles. P is the period register value, so P = 0 behaves like P = 1.
- R4: No pass starts while the enable bit is clear; clearing it during the wait between passes cancels the next pass.
- R5: After synchronous active-low reset, both registers read 0, and no request, log strobe or interrupt is active.
- R6: Control register read layout: bit 4 is a read-only pass-in-progress flag; bit 3 is enable, bit 1 is interrupt enable and bit 0 is a general-purpose bit, all three read/write. Bits 7:5 and 2 always read 0. The period register reads back what was written.
- R7: Each read that reports a single-bit error gives a one-cycle pulse on `sbe_log`. When the interrupt enable bit is set, the same pulse also appears on `irq`; otherwise `irq` stays low.
- R8: With `derr_mode` high, every word is written back, including words whose read reported a multi-bit error.
- R9: With `derr_mode` low, a read that reports a multi-bit error gives a one-cycle `mbe_log` pulse and skips the write-back, and the pass continues at the next address.
- R10: Every access holds `mem_req`, `mem_we` and `mem_addr` until `mem_gnt`. Reads cover addresses 0 to 2^ADDR_W−1 in ascending order. Each write-back goes to the address just read, carrying the corrected data returned with that read's grant.
- R11: If the enable bit is cleared in the middle of a pass, the pass still reads every remaining address up to the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| per_we | input | 1 | Period register write strobe |
| per_wdata | input | PER_W | Period register write data |
| per_rdata | output | PER_W | Period register read data |
| derr_mode | input | 1 | High: write back even after a multi-bit error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back (1) or a read (0) |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | DATA_W | Corrected data for the write-back |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | DATA_W | Corrected read data, valid with a read grant |
| ecc_sbe | input | 1 | Single-bit error flag, valid with a read grant |
| ecc_mbe | input | 1 | Multi-bit error flag, valid with a read grant |
| sbe_log | output | 1 | One-cycle strobe per corrected single-bit error |
| mbe_log | output | 1 | One-cycle strobe per skipped multi-bit word |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with TICK_CYC = 8, ADDR_W = 3 and DATA_W = 16. One period tick then lasts eight cycles and a pass covers eight words. These values bring the exact inter-pass gap for small and zero period values, the wrap from the last address, and a mid-pass enable clear within a few hundred cycles. With PER_W = 8, a period of 255 holds the scrubber in its wait state for long enough that the bench can stop it there deterministically between error-injection rounds.

// File: rtl/scrub_pkg.sv
// Package: shared state encoding and control register bit positions.
// Assumes: positions are visible to software and must not move.
package scrub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_WAIT = 2'd3
    } scrub_st_t;

    localparam int CTL_GP   = 0;
    localparam int CTL_IEN  = 1;
    localparam int CTL_EN   = 3;
    localparam int CTL_BUSY = 4;
endpackage

// File: rtl/scrub_regs.sv
// Module: control and period registers.
// Holds the enable, interrupt-enable and spare bits plus the period value,
// and assembles read data with the live pass-in-progress flag.
// Assumes: single-cycle write strobes; unused control bits read zero.
module scrub_regs #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             per_we,
    input  logic [PER_W-1:0] per_wdata,
    input  logic             busy,
    output logic [7:0]       ctl_rdata,
    output logic [PER_W-1:0] per_rdata,
    output logic             en,
    output logic             ien
);
    import scrub_pkg::*;

    logic             gp_q;
    logic [PER_W-1:0] per_q;

    // Register writes; reset clears every defined bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            ien   <= 1'b0;
            gp_q  <= 1'b0;
            per_q <= '0;
        end else begin
            if (ctl_we) begin
                en   <= ctl_wdata[CTL_EN];
                ien  <= ctl_wdata[CTL_IEN];
                gp_q <= ctl_wdata[CTL_GP];
            end
            if (per_we) per_q <= per_wdata;
        end
    end

    // Read data assembly with zero-filled reserved bits.
    always_comb begin
        ctl_rdata           = '0;
        ctl_rdata[CTL_GP]   = gp_q;
        ctl_rdata[CTL_IEN]  = ien;
        ctl_rdata[CTL_EN]   = en;
        ctl_rdata[CTL_BUSY] = busy;
    end

    assign per_rdata = per_q;
endmodule

// File: rtl/scrub_timer.sv
// Module: inter-pass interval timer.
// A prescaler produces a tick every TICK_CYC cycles; expire pulses when
// max(period,1) ticks have elapsed since run went high.
// Assumes: run stays high for the whole wait and drops right after expire.
module scrub_timer #(
    parameter int TICK_CYC = 200_000_000,
    parameter int PER_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             expire
);
    localparam int PRE_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYC - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PER_W-1:0] tk_q;
    logic             tick;
    logic [PER_W:0]   target;

    assign tick   = run && (pre_q == PRE_LAST);
    assign target = (period == '0) ? (PER_W+1)'(1) : {1'b0, period};
    assign expire = tick && (({1'b0, tk_q} + (PER_W+1)'(1)) >= target);

    // Prescaler and tick counter, both held at zero outside a wait.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
            tk_q  <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
            if (tick) tk_q <= tk_q + PER_W'(1);
        end
    end

    p_expire_in_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
endmodule

// File: rtl/scrub_walker.sv
// Module: pass sequencer and address walker.
// Starts a pass on an enable rise or a timer expiry, reads each word,
// writes the corrected word back (or skips it on a reported multi-bit
// error when error reporting is on), and decides idle or wait at the end.
// Assumes: read data and error flags are valid in the cycle of a read grant.
module scrub_walker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              derr_mode,
    input  logic              period_done,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              ecc_sbe,
    input  logic              ecc_mbe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              waiting,
    output logic              sbe_log,
    output logic              mbe_log
);
    import scrub_pkg::*;

    localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

    scrub_st_t         st;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              en_q;
    logic              at_last;
    scrub_st_t         end_st;

    assign at_last = (addr_q == ADDR_LAST);
    assign end_st  = en ? ST_WAIT : ST_IDLE;

    // Sequencer state, address and captured data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            en_q    <= 1'b0;
            sbe_log <= 1'b0;
            mbe_log <= 1'b0;
        end else begin
            en_q    <= en;
            sbe_log <= 1'b0;
            mbe_log <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (en && !en_q) begin
                        st     <= ST_RD;
                        addr_q <= '0;
                    end
                end
                ST_WAIT: begin
                    if (!en) begin
                        st <= ST_IDLE;
                    end else if (period_done) begin
                        st     <= ST_RD;
                        addr_q <= '0;
                    end
                end
                ST_RD: begin
                    if (mem_gnt) begin
                        wdata_q <= mem_rdata;
                        sbe_log <= ecc_sbe;
                        if (ecc_mbe && !derr_mode) begin
                            mbe_log <= 1'b1;
                            if (at_last) begin
                                st <= end_st;
                            end else begin
                                addr_q <= addr_q + ADDR_W'(1);
                            end
                        end else begin
                            st <= ST_WR;
                        end
                    end
                end
                default: begin
                    if (mem_gnt) begin
                        if (at_last) begin
                            st <= end_st;
                        end else begin
                            addr_q <= addr_q + ADDR_W'(1);
                            st     <= ST_RD;
                        end
                    end
                end
            endcase
        end
    end

    // Memory port outputs decoded from the sequencer state.
    always_comb begin
        mem_req   = (st == ST_RD) || (st == ST_WR);
        mem_we    = (st == ST_WR);
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        busy      = mem_req;
        waiting   = (st == ST_WAIT);
    end

    p_start_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en));
    p_start_addr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_addr == '0) && !mem_we);
    p_hold_until_gnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    p_mbe_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD && mem_gnt && ecc_mbe && !derr_mode) |=> !mem_we);
endmodule

// File: rtl/mem_scrub_ctrl.sv
// Module: top of the periodic ECC scrubber.
// Connects registers, interval timer and pass sequencer, and gates the
// single-bit log strobe into the interrupt pulse.
// Assumes: one clock domain; synchronous active-low reset.
module mem_scrub_ctrl #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 64,
    parameter int PER_W    = 8,
    parameter int TICK_CYC = 200_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              per_we,
    input  logic [PER_W-1:0]  per_wdata,
    output logic [PER_W-1:0]  per_rdata,
    input  logic              derr_mode,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              ecc_sbe,
    input  logic              ecc_mbe,
    output logic              sbe_log,
    output logic              mbe_log,
    output logic              irq
);
    logic en, ien, busy, waiting, period_done;

    scrub_regs #(.PER_W(PER_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .per_we(per_we), .per_wdata(per_wdata),
        .busy(busy), .ctl_rdata(ctl_rdata), .per_rdata(per_rdata),
        .en(en), .ien(ien)
    );

    scrub_timer #(.TICK_CYC(TICK_CYC), .PER_W(PER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(waiting),
        .period(per_rdata), .expire(period_done)
    );

    scrub_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .en(en), .derr_mode(derr_mode),
        .period_done(period_done), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .ecc_sbe(ecc_sbe), .ecc_mbe(ecc_mbe),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .waiting(waiting),
        .sbe_log(sbe_log), .mbe_log(mbe_log)
    );

    // Interrupt follows each logged single-bit error when enabled.
    assign irq = sbe_log && ien;

    p_irq_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_needs_sbe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_req && !mem_we && mem_gnt));
endmodule

// File: tb/mem_scrub_ctrl_bench.sv
module mem_scrub_ctrl_bench;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int PER_W  = 8;
    localparam int TICK   = 8;
    localparam int WORDS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_we = 1'b0;
    logic [7:0]        ctl_wdata = '0;
    logic [7:0]        ctl_rdata;
    logic              per_we = 1'b0;
    logic [PER_W-1:0]  per_wdata = '0;
    logic [PER_W-1:0]  per_rdata;
    logic              derr_mode = 1'b0;
    logic              mem_req, mem_we, sbe_log, mbe_log, irq;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_gnt = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              ecc_sbe = 1'b0;
    logic              ecc_mbe = 1'b0;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    logic [DATA_W-1:0] mem [WORDS];
    int  err [WORDS];
    int  rd_cnt = 0, wr_cnt = 0, sbe_cnt = 0, mbe_cnt = 0, irq_cnt = 0;
    int  exp_rd_addr = 0, last_rd_addr = 0, last_rd_err = 0;
    int  gnt_pct = 75;

    mem_scrub_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PER_W(PER_W),
                     .TICK_CYC(TICK)) u_mem_scrub_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .per_we(per_we), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .derr_mode(derr_mode), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .ecc_sbe(ecc_sbe),
        .ecc_mbe(ecc_mbe), .sbe_log(sbe_log), .mbe_log(mbe_log), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_gap(input int per);
        return ((per == 0) ? 1 : per) * TICK;
    endfunction

    function automatic int count_err(input int kind);
        int n = 0;
        for (int i = 0; i < WORDS; i++) if (err[i] == kind) n++;
        return n;
    endfunction

    // Memory / ECC model, grant decision and event counting at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (sbe_log) sbe_cnt++;
        if (mbe_log) mbe_cnt++;
        if (irq) irq_cnt++;
        mem_gnt = 1'b0;
        ecc_sbe = 1'b0;
        ecc_mbe = 1'b0;
        if (rst_n && mem_req && ($urandom_range(99) < gnt_pct)) begin
            mem_gnt = 1'b1;
            if (!mem_we) begin
                chk(int'(mem_addr) == exp_rd_addr, "R10 read order", int'(mem_addr), exp_rd_addr);
                exp_rd_addr  = (int'(mem_addr) + 1) % WORDS;
                last_rd_addr = int'(mem_addr);
                last_rd_err  = err[mem_addr];
                mem_rdata    = mem[mem_addr];
                ecc_sbe      = (err[mem_addr] == 1);
                ecc_mbe      = (err[mem_addr] == 2);
                rd_cnt++;
            end else begin
                chk(int'(mem_addr) == last_rd_addr, "R10 write address", int'(mem_addr), last_rd_addr);
                chk(mem_wdata == mem[mem_addr], "R10 write data", int'(mem_wdata), int'(mem[mem_addr]));
                chk(last_rd_err != 2 || derr_mode, "R9 write after mbe", last_rd_err, 0);
                err[mem_addr] = 0;
                wr_cnt++;
            end
        end
    end

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wdata = v; ctl_we = 1'b1;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_per(input int v);
        per_wdata = PER_W'(v); per_we = 1'b1;
        @(negedge clk); per_we = 1'b0;
    endtask

    task automatic clr_counts();
        rd_cnt = 0; wr_cnt = 0; sbe_cnt = 0; mbe_cnt = 0; irq_cnt = 0;
    endtask

    task automatic wait_busy(input bit lvl);
        while (ctl_rdata[4] != lvl) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mem_req) seen = 1'b1;
        end
        chk(!seen, req, int'(seen), 0);
    endtask

    // One pass with given error pattern, then the enable is dropped in the wait.
    task automatic err_pass(input bit dm, input bit ie);
        int ns, nm;
        ns = count_err(1); nm = count_err(2);
        derr_mode = dm;
        clr_counts();
        wr_ctl({4'b0, 1'b1, 1'b0, ie, 1'b0});
        wait_busy(1'b1);
        wait_busy(1'b0);
        repeat (3) @(negedge clk);
        chk(rd_cnt == WORDS, "R10 reads per pass", rd_cnt, WORDS);
        chk(sbe_cnt == ns, "R7 sbe strobes", sbe_cnt, ns);
        chk(irq_cnt == (ie ? ns : 0), "R7 irq pulses", irq_cnt, ie ? ns : 0);
        chk(mbe_cnt == (dm ? 0 : nm), "R9 mbe strobes", mbe_cnt, dm ? 0 : nm);
        chk(wr_cnt == WORDS - (dm ? 0 : nm), dm ? "R8 write-backs" : "R9 write-backs",
            wr_cnt, WORDS - (dm ? 0 : nm));
        chk(count_err(2) == (dm ? 0 : nm), dm ? "R8 mbe words rewritten" : "R9 mbe words kept",
            count_err(2), dm ? 0 : nm);
        chk(count_err(1) == 0, "R10 sbe words corrected", count_err(1), 0);
        wr_ctl(8'h00);
        quiet(20, "R4 no pass after clear in wait");
    endtask

    initial begin
        int gap, s;
        s = $urandom(32'd20240611);
        for (int i = 0; i < WORDS; i++) begin mem[i] = DATA_W'($urandom); err[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        chk(ctl_rdata == 8'h00, "R5 ctl reset", int'(ctl_rdata), 0);
        chk(per_rdata == '0, "R5 period reset", int'(per_rdata), 0);
        chk(!mem_req && !irq && !sbe_log && !mbe_log, "R5 outputs idle",
            int'({mem_req, irq, sbe_log, mbe_log}), 0);

        // R6 register layout, no enable
        wr_ctl(8'hE7);
        chk(ctl_rdata == 8'h03, "R6 reserved bits zero", int'(ctl_rdata), 3);
        wr_per(8'hA5);
        chk(per_rdata == 8'hA5, "R6 period readback", int'(per_rdata), 165);
        wr_ctl(8'h00);
        quiet(10, "R4 no pass while disabled");

        // R1 immediate start, R6 busy flag, R3 gap with P=3 and P=0
        wr_per(3);
        gnt_pct = 100;
        clr_counts();
        wr_ctl(8'h08);
        chk(!mem_req, "R1 no request before start", int'(mem_req), 0);
        @(negedge clk);
        chk(mem_req && !mem_we && mem_addr == '0, "R1 immediate read of address 0",
            int'({mem_req, mem_we}), 2);
        chk(ctl_rdata[4], "R6 busy during pass", int'(ctl_rdata[4]), 1);
        gnt_pct = 60;
        wait_busy(1'b0);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!mem_req && gap < 5000);
        chk(gap == exp_gap(3), "R3 gap P=3", gap, exp_gap(3));
        wr_per(0);
        wait_busy(1'b0);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!mem_req && gap < 5000);
        chk(gap == exp_gap(0), "R3 gap P=0", gap, exp_gap(0));

        // R11 mid-pass clear completes the pass; R2 then idle
        wait_busy(1'b0);
        wait_busy(1'b1);
        clr_counts();
        while (rd_cnt < 3) @(negedge clk);
        wr_ctl(8'h00);
        wait_busy(1'b0);
        chk(rd_cnt == WORDS, "R11 pass runs to last address", rd_cnt, WORDS);
        quiet(60, "R2 idle after pass with enable clear");

        // R4 clear during wait
        wr_per(3);
        wr_ctl(8'h08);
        wait_busy(1'b1);
        wait_busy(1'b0);
        repeat (4) @(negedge clk);
        wr_ctl(8'h00);
        quiet(60, "R4 wait cancelled");

        // Directed error passes: R7 R8 R9
        wr_per(255);
        err[1] = 1; err[4] = 2; err[7] = 1;
        err_pass(1'b0, 1'b1);
        err[0] = 2; err[2] = 1; err[4] = 2;
        err_pass(1'b1, 1'b1);
        err[3] = 1; err[5] = 2;
        err_pass(1'b0, 1'b0);

        // Random rounds
        for (int r = 0; r < 6; r++) begin
            gnt_pct = 30 + $urandom_range(70);
            for (int i = 0; i < WORDS; i++) err[i] = $urandom_range(3) % 3;
            err_pass(1'($urandom_range(1)), 1'($urandom_range(1)));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        if (!done && cyc > 150000) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule